// File: doc/BRIEF.md
# DMA Channel Interrupt Status Tracker

This block keeps the interrupt and activity status for a small group of DMA channels that move data as two-dimensional transfers: rows of X beats, repeated Y times. The data mover sits outside the block and sends it a one-cycle strobe for each beat it completes and for each error it detects. From these strobes the block counts its way through each row and each buffer. Depending on how the channel was set up, it raises a completion interrupt at the end of every row, at the end of the whole buffer, or never.

Software sets up a channel by writing its configuration: an enable, a flow mode, an interrupt selection and the X and Y counts. That write starts the channel running. Flow modes that fetch a descriptor also show a fetch phase of fixed length before beats are counted. Software reads a 16-bit status word per channel through a one-cycle-latency read port. It clears the completion and error flags by writing ones to them. The error flags of all channels are merged into one global error interrupt.

Top module: `dmast_top`

## Requirements
- R1: After reset every status word reads 0x0000, and `done_irq` and `err_irq` are low.
- R2: The status word has bit 0 = completion, bit 1 = error, bit 2 = descriptor fetch and bit 3 = running; bits 15..4 read 0. `rd_data` and `rd_vld` are valid on the clock edge after the one that samples `rd_en`.
- R3: A config write with `cfg_en`=1 sets the running flag. The fetch flag is also set when `cfg_flow` is 4..7 and stays clear when `cfg_flow` is 0..3. A config write with `cfg_en`=0 clears both flags.
- R4: The fetch flag reads 1 for FETCH_CYC cycles (4 by default) after the config write and then clears by itself. Beat strobes are ignored while the channel is fetching or not running.
- R5: Each counted beat decrements the X count. The beat that finds X at 1 ends a row: X reloads and Y decrements. With `cfg_isel`=1 (row), every row end sets the completion flag.
- R6: With `cfg_isel`=2 (buffer), the completion flag is set only when a row ends with Y at 1. In flow mode 0 the running flag clears at that point; in other modes the counts reload and the channel keeps running.
- R7: With `cfg_isel`=0 or 3, beats never set the completion flag.
- R8: A status write with bit 0 or bit 1 set clears the completion or error flag of channel `st_ch`. A 0 in those bits has no effect, and writes to bits 2 and 3 are ignored. If a set event and a clear fall on the same cycle, the set wins.
- R9: `done_irq[c]` follows channel c's completion flag and stays high until software clears it.
- R10: An `err_stb[c]` pulse sets the error flag of channel c and clears its running and fetch flags. The channel's stored configuration is kept.
- R11: `err_irq` is the OR of all channels' error flags, registered one cycle later.
- R12: A configured X or Y count of 0 behaves as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel selected by the configuration write |
| cfg_en | input | 1 | Channel enable |
| cfg_flow | input | 3 | Flow mode (0 stop, 1..3 no fetch, 4..7 fetch descriptor) |
| cfg_isel | input | 2 | Interrupt select: 0 none, 1 row, 2 buffer, 3 none |
| cfg_x | input | CW | Beats per row |
| cfg_y | input | CW | Rows per buffer |
| st_we | input | 1 | Status write strobe (write-one-to-clear) |
| st_ch | input | CHW | Channel selected by the status write |
| st_wdata | input | 16 | Status write data |
| rd_en | input | 1 | Status read request |
| rd_ch | input | CHW | Channel selected by the read |
| rd_data | output | 16 | Status word that was read |
| rd_vld | output | 1 | rd_data valid |
| beat | input | NCH | One-cycle beat-complete strobe per channel |
| err_stb | input | NCH | One-cycle error strobe per channel |
| done_irq | output | NCH | Per-channel completion interrupt |
| err_irq | output | 1 | Global DMA error interrupt |

## Verification
The assertions assume that the strobes and writes are sampled only at clock edges and that channel selects stay below NCH. They also assume that a status clear of bit 0 without a same-cycle beat to that channel takes effect on the next edge. The bench drives every input on the falling edge, so each strobe covers exactly one rising edge. It uses only channel numbers 0..3. It avoids a beat in the same cycle as a completion clear, except where the set-wins rule is what is being examined.

// File: rtl/dmast_pkg.sv
package dmast_pkg;
  localparam int STW = 16;
  localparam int B_DONE  = 0;
  localparam int B_ERR   = 1;
  localparam int B_FETCH = 2;
  localparam int B_RUN   = 3;

  typedef enum logic [1:0] {
    ISEL_NONE = 2'd0,
    ISEL_ROW  = 2'd1,
    ISEL_BUF  = 2'd2,
    ISEL_OFF  = 2'd3
  } isel_e;

  typedef struct packed {
    logic run;
    logic fetch;
    logic err;
    logic done;
  } chst_t;

  function automatic logic [STW-1:0] pack_status(input chst_t s);
    logic [STW-1:0] w;
    w = '0;
    w[B_DONE]  = s.done;
    w[B_ERR]   = s.err;
    w[B_FETCH] = s.fetch;
    w[B_RUN]   = s.run;
    return w;
  endfunction
endpackage

// File: rtl/dmast_chan.sv
module dmast_chan
  import dmast_pkg::*;
#(
  parameter int CW        = 8,
  parameter int FETCH_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_en,
  input  logic [2:0]    cfg_flow,
  input  logic [1:0]    cfg_isel,
  input  logic [CW-1:0] cfg_x,
  input  logic [CW-1:0] cfg_y,
  input  logic          beat,
  input  logic          err_stb,
  input  logic          clr_done,
  input  logic          clr_err,
  output chst_t         st
);
  localparam int FW = (FETCH_CYC > 1) ? $clog2(FETCH_CYC) : 1;
  localparam logic [FW-1:0] FLAST = FW'(FETCH_CYC - 1);

  logic [CW-1:0] x_len, y_len, cur_x, cur_y;
  logic [2:0]    flow_q;
  isel_e         isel_q;
  logic [FW-1:0] fcnt;
  logic          done_q, err_q, fetch_q, run_q;
  logic          active, row_end, buf_end, irq_hit;

  assign active  = run_q && !fetch_q;
  assign row_end = active && beat && (cur_x <= CW'(1));
  assign buf_end = row_end && (cur_y <= CW'(1));
  assign irq_hit = ((isel_q == ISEL_ROW) && row_end) ||
                   ((isel_q == ISEL_BUF) && buf_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_len   <= '0;
      y_len   <= '0;
      cur_x   <= '0;
      cur_y   <= '0;
      flow_q  <= '0;
      isel_q  <= ISEL_NONE;
      fcnt    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fetch_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (cfg_we) begin
        x_len   <= cfg_x;
        y_len   <= cfg_y;
        cur_x   <= cfg_x;
        cur_y   <= cfg_y;
        flow_q  <= cfg_flow;
        isel_q  <= isel_e'(cfg_isel);
        run_q   <= cfg_en;
        fetch_q <= cfg_en && cfg_flow[2];
        fcnt    <= '0;
      end else begin
        if (fetch_q) begin
          if (fcnt == FLAST) fetch_q <= 1'b0;
          else               fcnt    <= fcnt + 1'b1;
        end
        if (active && beat) begin
          if (row_end) begin
            cur_x <= x_len;
            if (buf_end) begin
              cur_y <= y_len;
              if (flow_q == 3'd0) run_q <= 1'b0;
            end else begin
              cur_y <= cur_y - 1'b1;
            end
          end else begin
            cur_x <= cur_x - 1'b1;
          end
        end
      end
      // error: flag up, channel stops; stored config untouched
      if (err_stb) begin
        err_q   <= 1'b1;
        run_q   <= 1'b0;
        fetch_q <= 1'b0;
      end else if (clr_err) begin
        err_q <= 1'b0;
      end
      if (irq_hit)       done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  assign st.done  = done_q;
  assign st.err   = err_q;
  assign st.fetch = fetch_q;
  assign st.run   = run_q;
endmodule

// File: rtl/dmast_rdport.sv
module dmast_rdport
  import dmast_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic [CHW-1:0] rd_ch,
  input  chst_t          st_v [NCH],
  output logic [STW-1:0] rd_data,
  output logic           rd_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= pack_status(st_v[rd_ch]);
    end
  end
endmodule

// File: rtl/dmast_top.sv
module dmast_top
  import dmast_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CW        = 8,
  parameter int FETCH_CYC = 4,
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic           cfg_en,
  input  logic [2:0]     cfg_flow,
  input  logic [1:0]     cfg_isel,
  input  logic [CW-1:0]  cfg_x,
  input  logic [CW-1:0]  cfg_y,
  input  logic           st_we,
  input  logic [CHW-1:0] st_ch,
  input  logic [15:0]    st_wdata,
  input  logic           rd_en,
  input  logic [CHW-1:0] rd_ch,
  output logic [15:0]    rd_data,
  output logic           rd_vld,
  input  logic [NCH-1:0] beat,
  input  logic [NCH-1:0] err_stb,
  output logic [NCH-1:0] done_irq,
  output logic           err_irq
);
  chst_t          st_v [NCH];
  logic [NCH-1:0] err_v, run_v, fetch_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_cfg, sel_st;
    assign sel_cfg = cfg_we && (cfg_ch == CHW'(c));
    assign sel_st  = st_we  && (st_ch  == CHW'(c));

    dmast_chan #(.CW(CW), .FETCH_CYC(FETCH_CYC)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (sel_cfg),
      .cfg_en   (cfg_en),
      .cfg_flow (cfg_flow),
      .cfg_isel (cfg_isel),
      .cfg_x    (cfg_x),
      .cfg_y    (cfg_y),
      .beat     (beat[c]),
      .err_stb  (err_stb[c]),
      .clr_done (sel_st && st_wdata[B_DONE]),
      .clr_err  (sel_st && st_wdata[B_ERR]),
      .st       (st_v[c])
    );

    assign done_irq[c] = st_v[c].done;
    assign err_v[c]    = st_v[c].err;
    assign run_v[c]    = st_v[c].run;
    assign fetch_v[c]  = st_v[c].fetch;
  end

  always_ff @(posedge clk) begin
    if (rst) err_irq <= 1'b0;
    else     err_irq <= |err_v;
  end

  dmast_rdport #(.NCH(NCH), .CHW(CHW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_ch   (rd_ch),
    .st_v    (st_v),
    .rd_data (rd_data),
    .rd_vld  (rd_vld)
  );
endmodule

// File: rtl/dmast_chk.sv
module dmast_chk #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           st_we,
  input logic [CHW-1:0] st_ch,
  input logic [15:0]    st_wdata,
  input logic [NCH-1:0] beat,
  input logic [NCH-1:0] err_stb,
  input logic [NCH-1:0] err_v,
  input logic [NCH-1:0] run_v,
  input logic [NCH-1:0] fetch_v,
  input logic [NCH-1:0] done_irq,
  input logic           err_irq
);
  // R11
  err_irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|err_v) |=> err_irq);
  // R11
  err_irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|err_v) |=> !err_irq);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R10
    err_stop_chk: assert property (@(posedge clk) disable iff (rst)
      err_stb[c] |=> (err_v[c] && !run_v[c] && !fetch_v[c]));
    // R8
    done_w1c_chk: assert property (@(posedge clk) disable iff (rst)
      (st_we && st_ch == CHW'(c) && st_wdata[0] && !beat[c]) |=> !done_irq[c]);
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (err_v[c] && !(st_we && st_ch == CHW'(c) && st_wdata[1])) |=> err_v[c]);
    // R3
    fetch_run_chk: assert property (@(posedge clk) disable iff (rst)
      fetch_v[c] |-> run_v[c]);
  end
endmodule

bind dmast_top dmast_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst(rst), .st_we(st_we), .st_ch(st_ch), .st_wdata(st_wdata),
  .beat(beat), .err_stb(err_stb), .err_v(err_v), .run_v(run_v),
  .fetch_v(fetch_v), .done_irq(done_irq), .err_irq(err_irq)
);

// File: tb/dmast_top_tb.sv
module dmast_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 8;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_en = 0;
  logic [1:0] cfg_ch = 0, st_ch = 0, rd_ch = 0, cfg_isel = 0;
  logic [2:0] cfg_flow = 0;
  logic [CW-1:0] cfg_x = 0, cfg_y = 0;
  logic st_we = 0, rd_en = 0;
  logic [15:0] st_wdata = 0;
  logic [15:0] rd_data;
  logic rd_vld;
  logic [NCH-1:0] beat = 0, err_stb = 0, done_irq;
  logic err_irq;

  int n_run = 0, n_fail = 0, cyc_cnt = 0;
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmast_top #(.NCH(NCH), .CW(CW), .FETCH_CYC(4)) u_dut (
    .clk, .rst, .cfg_we, .cfg_ch, .cfg_en, .cfg_flow, .cfg_isel, .cfg_x,
    .cfg_y, .st_we, .st_ch, .st_wdata, .rd_en, .rd_ch, .rd_data, .rd_vld,
    .beat, .err_stb, .done_irq, .err_irq);

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_vld) begin
      if (q_exp.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: unexpected read data 0x%0h expected none", rd_data);
      end else begin
        chk(rd_data, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  task automatic rd(input int ch, input logic [15:0] exp, input string tag);
    rd_en = 1; rd_ch = 2'(ch);
    q_exp.push_back(exp); q_tag.push_back(tag);
    step();
    rd_en = 0;
  endtask

  task automatic cfg(input int ch, input logic en, input int flow, input int isel,
                     input int x, input int y);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_en = en; cfg_flow = 3'(flow);
    cfg_isel = 2'(isel); cfg_x = CW'(x); cfg_y = CW'(y);
    step();
    cfg_we = 0;
  endtask

  task automatic pulse(input int ch);
    beat[ch] = 1; step(); beat = 0;
  endtask

  task automatic stw(input int ch, input logic [15:0] d);
    st_we = 1; st_ch = 2'(ch); st_wdata = d; step(); st_we = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 20000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
      end
    end
  end

  initial begin
    step(); step(); rst = 0; step();
    // R1 reset state
    chk({15'd0, err_irq}, 16'd0, "R1 err_irq");
    chk({12'd0, done_irq}, 16'd0, "R1 done_irq");
    rd(0, 16'h0000, "R1 status ch0");

    // R3 flow 1 run only; R5 row completion
    cfg(0, 1, 1, 1, 3, 2);
    rd(0, 16'h0008, "R3 run without fetch");
    pulse(0); pulse(0);
    chk({15'd0, done_irq[0]}, 16'd0, "R5 before row end");
    pulse(0);
    chk({15'd0, done_irq[0]}, 16'd1, "R5 row end");
    rd(0, 16'h0009, "R2 done+run layout");
    // R8 / R9 W1C
    stw(0, 16'h0000);
    chk({15'd0, done_irq[0]}, 16'd1, "R9 held on zero write");
    stw(0, 16'h0001);
    chk({15'd0, done_irq[0]}, 16'd0, "R8 W1C done");
    pulse(0); pulse(0); pulse(0);
    chk({15'd0, done_irq[0]}, 16'd1, "R5 second row");
    stw(0, 16'h0001);

    // R6 buffer completion, flow 0 stops
    cfg(1, 1, 0, 2, 2, 2);
    pulse(1); pulse(1); pulse(1);
    chk({15'd0, done_irq[1]}, 16'd0, "R6 mid buffer");
    pulse(1);
    chk({15'd0, done_irq[1]}, 16'd1, "R6 buffer end");
    rd(1, 16'h0001, "R6 flow0 run cleared");
    pulse(1);
    stw(1, 16'h0001);
    pulse(1); pulse(1); pulse(1); pulse(1);
    chk({15'd0, done_irq[1]}, 16'd0, "R4 beats ignored when stopped");

    // R3/R4 descriptor fetch
    cfg(2, 1, 5, 1, 1, 1);
    rd(2, 16'h000C, "R3 fetch+run on flow5");
    pulse(2);
    chk({15'd0, done_irq[2]}, 16'd0, "R4 beat ignored during fetch");
    step(); step(); step();
    rd(2, 16'h0008, "R4 fetch cleared");
    pulse(2);
    chk({15'd0, done_irq[2]}, 16'd1, "R5 after fetch");
    stw(2, 16'h0001);
    stw(2, 16'h000C);
    rd(2, 16'h0008, "R8 bits 2,3 write ignored");

    // R10/R11 error
    cfg(3, 1, 6, 0, 4, 4);
    err_stb[3] = 1; step(); err_stb = 0;
    step();
    chk({15'd0, err_irq}, 16'd1, "R11 err_irq set");
    rd(3, 16'h0002, "R10 err set, run/fetch cleared");
    stw(3, 16'h0001);
    rd(3, 16'h0002, "R8 done clear leaves err");
    stw(3, 16'h0002);
    step();
    chk({15'd0, err_irq}, 16'd0, "R11 err_irq cleared");

    // R7 no-interrupt selections
    cfg(0, 1, 1, 0, 1, 1);
    pulse(0); pulse(0);
    chk({15'd0, done_irq[0]}, 16'd0, "R7 isel 0");
    cfg(0, 1, 1, 3, 1, 1);
    pulse(0);
    chk({15'd0, done_irq[0]}, 16'd0, "R7 isel 3");
    // R3 disable
    cfg(0, 0, 5, 1, 1, 1);
    rd(0, 16'h0000, "R3 disable clears run/fetch");

    // R12 zero count
    cfg(1, 1, 1, 1, 0, 3);
    pulse(1);
    chk({15'd0, done_irq[1]}, 16'd1, "R12 zero X acts as one");
    // R8 set wins over clear
    beat[1] = 1; st_we = 1; st_ch = 2'd1; st_wdata = 16'h0001;
    step(); beat = 0; st_we = 0;
    chk({15'd0, done_irq[1]}, 16'd1, "R8 set wins over clear");

    step(); step();
    summary();
  end
endmodule